// File: doc/BRIEF.md
# MDIO Management Frame Engine

This block is the master side of a two-wire PHY management link. A host hands it one 32-bit command word. The word already carries the start, opcode, PHY address, register address, turnaround and data fields of a clause-22 frame. The engine sends a 32-bit preamble of ones on the data line, then shifts the command word out most significant bit first, timed by a management clock that it generates from the system clock.

For a read command the engine lets go of the data line at the second turnaround bit. It then samples the sixteen bits the PHY returns and places them in a read-data register. When any frame ends, an event flag is set. The host clears the flag by writing a one to it.

A typical host sequence has four steps:
1. Write the clock divider.
2. Write the command word.
3. Poll the event flag.
4. Clear the flag and, after a read, take the result.

The divider value present when the command is accepted sets the clock for that whole frame. If the divider is written in the same cycle as the command, that new value is used.

Top module: `mdio_frame_engine`

## Requirements
- R1: During and right after reset, `mdc` is 0, `mdio_oe` is 0, `evt_flag` is 0 and `rd_data` is 0; while no frame runs, `mdc` and `mdio_oe` stay 0.
- R2: An accepted command produces 64 frame bits: 32 ones, then `cmd_word[31]` down to `cmd_word[0]`, so frame bit k (k ≥ 32) carries `cmd_word[63-k]`.
- R3: Each management clock period is 2×(D+1) system clocks. D is `div_in` if `div_wr` is high in the accept cycle, else the last written divider.
- R4: `mdio_o` and `mdio_oe` change only on falling `mdc` edges or when a frame starts; they never change while `mdc` rises or is high.
- R5: A command whose bits 29:28 are 2'b10 is a read: `mdio_oe` goes low from frame bit 47 (second turnaround) through bit 63. Any other opcode keeps `mdio_oe` high for all 64 bits.
- R6: For a read, `mdio_i` is sampled on the rising `mdc` edges of frame bits 48 to 63, first sample into bit 15. The 16-bit result appears on `rd_data` in the cycle the frame ends.
- R7: A frame has exactly 64 rising `mdc` edges. `evt_flag` rises 128×(D+1) system clocks after the accept edge.
- R8: `evt_flag` stays set until a cycle with `evt_wr` high and `evt_wdata` 1; a write with `evt_wdata` 0 leaves it set.
- R9: A `cmd_wr` while a frame runs is ignored; the running frame's bits and opcode stay unchanged.
- R10: A write frame leaves `rd_data` unchanged.
- R11: A divider write during a frame does not alter that frame's clock period; it applies to the next command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Host strobe: start a frame with `cmd_word` |
| cmd_word | input | 32 | Packed management command |
| div_wr | input | 1 | Host strobe: store `div_in` as clock divider |
| div_in | input | DIV_W | Clock divider value D |
| evt_wr | input | 1 | Host write strobe to the event flag |
| evt_wdata | input | 1 | Write-one-to-clear data for the event flag |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven to the line |
| mdio_oe | output | 1 | Output enable for `mdio_o` |
| mdio_i | input | 1 | Management data read from the line |
| evt_flag | output | 1 | Frame-completion event |
| rd_data | output | 16 | Data returned by the last read frame |

## Verification
The bench records every bit on the line at each rising management clock edge. It compares these bits against the preamble and command word. A design that counts preamble or frame bits wrong shows a shifted bit pattern and a wrong edge count.

Read frames are checked for the exact bit where the output enable drops. Releasing one bit early or late would fight the PHY or lose the turnaround. The returned data is driven bit by bit, so a design that samples on the wrong edge or in the wrong order returns a rotated or reversed value.

Two cases target the divider:
- A divider write in the same cycle as the command must take effect for that command.
- A second command plus a divider write in mid-frame must leave the running frame untouched, with the new divider appearing only in the next frame.

A latching bug would show up as wrong clock intervals or a corrupted bit stream. The bench also checks that a clear write carrying a zero does not drop the event flag.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;

  localparam int PRE_BITS    = 32;
  localparam int CMD_BITS    = 32;
  localparam int DATA_BITS   = 16;
  localparam int FRAME_BITS  = PRE_BITS + CMD_BITS;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  // opcode position inside the command word
  localparam int OP_HI       = 29;
  localparam int OP_LO       = 28;
  localparam logic [1:0] OP_READ = 2'b10;
  // frame index of the second turnaround bit and first returned data bit
  localparam int RELEASE_IDX = PRE_BITS + (CMD_BITS - 1 - DATA_BITS);
  localparam int CAPTURE_IDX = RELEASE_IDX + 1;

  function automatic logic is_read_cmd(input logic [CMD_BITS-1:0] w);
    return w[OP_HI:OP_LO] == OP_READ;
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_now,
  output logic             fall_now
);

  logic [DIV_W-1:0] half_cnt;
  logic [DIV_W-1:0] div_q;
  logic             half_done;

  assign half_done = run && (half_cnt == div_q);
  assign rise_now  = half_done && !mdc;
  assign fall_now  = half_done && mdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_cnt <= '0;
      div_q    <= '0;
      mdc      <= 1'b0;
    end else if (start) begin
      half_cnt <= '0;
      div_q    <= div;
      mdc      <= 1'b0;
    end else if (!run) begin
      half_cnt <= '0;
      mdc      <= 1'b0;
    end else if (half_done) begin
      half_cnt <= '0;
      mdc      <= ~mdc;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
  import mdio_eng_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [CMD_BITS-1:0]  cmd,
  input  logic                 rise_now,
  input  logic                 fall_now,
  input  logic                 mdio_i,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 active,
  output logic                 is_read,
  output logic                 last_fall,
  output logic [DATA_BITS-1:0] cap_data
);

  logic [FRAME_BITS-1:0] shreg;
  logic [IDX_W-1:0]      idx;
  logic [IDX_W-1:0]      idx_nxt;
  logic                  at_last;
  logic                  in_capture;

  assign idx_nxt    = idx + 1'b1;
  assign at_last    = (idx == IDX_W'(FRAME_BITS - 1));
  assign last_fall  = active && fall_now && at_last;
  assign in_capture = is_read && (idx >= IDX_W'(CAPTURE_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg    <= '0;
      idx      <= '0;
      active   <= 1'b0;
      is_read  <= 1'b0;
      mdio_o   <= 1'b0;
      mdio_oe  <= 1'b0;
      cap_data <= '0;
    end else if (start) begin
      shreg    <= {{PRE_BITS{1'b1}}, cmd};
      idx      <= '0;
      active   <= 1'b1;
      is_read  <= is_read_cmd(cmd);
      mdio_o   <= 1'b1;
      mdio_oe  <= 1'b1;
      cap_data <= '0;
    end else if (active && fall_now) begin
      if (at_last) begin
        active  <= 1'b0;
        mdio_o  <= 1'b0;
        mdio_oe <= 1'b0;
      end else begin
        idx     <= idx_nxt;
        shreg   <= shreg << 1;
        mdio_o  <= shreg[FRAME_BITS-2];
        mdio_oe <= !(is_read && (idx_nxt >= IDX_W'(RELEASE_IDX)));
      end
    end else if (active && rise_now && in_capture) begin
      cap_data <= {cap_data[DATA_BITS-2:0], mdio_i};
    end
  end

endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_eng_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 div_wr,
  input  logic [DIV_W-1:0]     div_in,
  input  logic                 evt_wr,
  input  logic                 evt_wdata,
  input  logic                 frame_done,
  input  logic                 done_read,
  input  logic [DATA_BITS-1:0] cap_data,
  output logic [DIV_W-1:0]     div_eff,
  output logic                 evt_flag,
  output logic [DATA_BITS-1:0] rd_data
);

  logic [DIV_W-1:0] div_reg;

  // same-cycle divider write is seen by a command accepted in that cycle
  assign div_eff = div_wr ? div_in : div_reg;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_reg  <= '0;
      evt_flag <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (div_wr) div_reg <= div_in;
      if (frame_done)                evt_flag <= 1'b1;
      else if (evt_wr && evt_wdata)  evt_flag <= 1'b0;
      if (frame_done && done_read)   rd_data  <= cap_data;
    end
  end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_eng_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_wr,
  input  logic [CMD_BITS-1:0]  cmd_word,
  input  logic                 div_wr,
  input  logic [DIV_W-1:0]     div_in,
  input  logic                 evt_wr,
  input  logic                 evt_wdata,
  output logic                 mdc,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  input  logic                 mdio_i,
  output logic                 evt_flag,
  output logic [DATA_BITS-1:0] rd_data
);

  logic                 accept;
  logic                 frame_active;
  logic                 frame_read;
  logic                 rise_now;
  logic                 fall_now;
  logic                 last_fall;
  logic [DIV_W-1:0]     div_eff;
  logic [DATA_BITS-1:0] cap_data;

  // commands arriving mid-frame are dropped
  assign accept = cmd_wr && !frame_active;

  mdio_host_regs #(.DIV_W(DIV_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .div_wr    (div_wr),
    .div_in    (div_in),
    .evt_wr    (evt_wr),
    .evt_wdata (evt_wdata),
    .frame_done(last_fall),
    .done_read (frame_read),
    .cap_data  (cap_data),
    .div_eff   (div_eff),
    .evt_flag  (evt_flag),
    .rd_data   (rd_data)
  );

  mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .run      (frame_active),
    .div      (div_eff),
    .mdc      (mdc),
    .rise_now (rise_now),
    .fall_now (fall_now)
  );

  mdio_frame_shifter u_shift (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .cmd      (cmd_word),
    .rise_now (rise_now),
    .fall_now (fall_now),
    .mdio_i   (mdio_i),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .active   (frame_active),
    .is_read  (frame_read),
    .last_fall(last_fall),
    .cap_data (cap_data)
  );

endmodule

// File: rtl/mdio_frame_engine_chk.sv
module mdio_frame_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        evt_flag,
  input logic        evt_wr,
  input logic        evt_wdata,
  input logic [15:0] rd_data,
  input logic        frame_active,
  input logic        frame_read
);

  // R4: line outputs hold across a rising clock edge
  a_r4_stable_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R4: line outputs hold while the clock stays high
  a_r4_stable_high: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R1: no clock and no drive outside a frame
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !frame_active |-> (!mdc && !mdio_oe));

  // R5: only read frames release the line
  a_r5_release_read_only: assert property (@(posedge clk) disable iff (rst)
    (frame_active && !mdio_oe) |-> frame_read);

  // R8: the flag persists until a write of one
  a_r8_evt_holds: assert property (@(posedge clk) disable iff (rst)
    (evt_flag && !(evt_wr && evt_wdata)) |=> evt_flag);

  // R6: read data only moves as a frame ends
  a_r6_rd_at_end: assert property (@(posedge clk) disable iff (rst)
    $changed(rd_data) |-> $fell(frame_active));

  // R9: the frame kind cannot change mid-frame
  a_r9_kind_stable: assert property (@(posedge clk) disable iff (rst)
    (frame_active && $past(frame_active)) |-> $stable(frame_read));

endmodule

bind mdio_frame_engine mdio_frame_engine_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .mdc         (mdc),
  .mdio_o      (mdio_o),
  .mdio_oe     (mdio_oe),
  .evt_flag    (evt_flag),
  .evt_wr      (evt_wr),
  .evt_wdata   (evt_wdata),
  .rd_data     (rd_data),
  .frame_active(frame_active),
  .frame_read  (frame_read)
);

// File: tb/mdio_frame_engine_bench.sv
`timescale 1ns/1ps
module mdio_frame_engine_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        div_wr = 1'b0;
  logic [7:0]  div_in = '0;
  logic        evt_wr = 1'b0;
  logic        evt_wdata = 1'b0;
  logic        mdc, mdio_o, mdio_oe, mdio_i, evt_flag;
  logic [15:0] rd_data;

  always #4 clk = ~clk;

  mdio_frame_engine u_mdio_frame_engine (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .div_wr(div_wr), .div_in(div_in), .evt_wr(evt_wr), .evt_wdata(evt_wdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .evt_flag(evt_flag), .rd_data(rd_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // line monitor and PHY model
  int   cyc = 0, nrise = 0, last_rise = 0, ivl_bad = 0, ivl_exp = 2, r4_bad = 0;
  logic bo [64];
  logic boe [64];
  logic prev_mdc = 1'b0, prev_o = 1'b0;
  logic [15:0] phy_val = '0;

  always @(negedge clk) begin
    cyc++;
    if (mdio_o !== prev_o && mdc) r4_bad++;
    if (mdc && !prev_mdc) begin
      if (nrise < 64) begin bo[nrise] = mdio_o; boe[nrise] = mdio_oe; end
      if (nrise > 0 && (cyc - last_rise) != ivl_exp) ivl_bad++;
      last_rise = cyc;
      nrise++;
    end
    prev_mdc = mdc;
    prev_o   = mdio_o;
  end

  always_comb mdio_i = (nrise >= 48 && nrise < 64) ? phy_val[63 - nrise] : 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cmd(input bit rd, input logic [4:0] phy,
                                         input logic [4:0] rg, input logic [15:0] wd);
    if (rd) return 32'h6002_0000 | ({27'd0, phy} << 23) | ({27'd0, rg} << 18);
    return 32'h5002_0000 | ({27'd0, phy} << 23) | ({27'd0, rg} << 18) | {16'd0, wd};
  endfunction

  task automatic run_frame(input logic [31:0] cmd, input int d, input bit wr_div,
                           input bit inject, output int len);
    nrise = 0; ivl_bad = 0; r4_bad = 0; ivl_exp = 2 * (d + 1);
    @(negedge clk);
    cmd_wr = 1'b1; cmd_word = cmd; div_wr = wr_div; div_in = 8'(d);
    @(negedge clk);
    cmd_wr = 1'b0; div_wr = 1'b0; len = 1;
    while (!evt_flag && len < 20000) begin
      @(negedge clk);
      len++;
      if (inject && len == 40) begin
        cmd_wr = 1'b1; cmd_word = ~cmd; div_wr = 1'b1; div_in = 8'(d + 2);
      end else begin
        cmd_wr = 1'b0; div_wr = 1'b0;
      end
    end
  endtask

  task automatic verify(input logic [31:0] cmd, input bit rd, input int d, input int len,
                        input logic [15:0] exp_rd);
    int pre_bad = 0, cmd_bad = 0, oe_bad = 0;
    chk(len - 1 == 128 * (d + 1), "R7", "frame length", 64'(len - 1), 64'(128 * (d + 1)));
    chk(nrise == 64, "R7", "rising edges", 64'(nrise), 64);
    for (int i = 0; i < 32; i++) if (bo[i] !== 1'b1) pre_bad++;
    for (int i = 32; i < 64; i++)
      if ((!rd || i < 47) && bo[i] !== cmd[63 - i]) cmd_bad++;
    chk(pre_bad == 0 && cmd_bad == 0, "R2", "bit errors", 64'(pre_bad + cmd_bad), 0);
    for (int i = 0; i < 64; i++)
      if (boe[i] !== ((rd && i >= 47) ? 1'b0 : 1'b1)) oe_bad++;
    chk(oe_bad == 0, "R5", "enable errors", 64'(oe_bad), 0);
    chk(ivl_bad == 0, "R3", "period errors", 64'(ivl_bad), 0);
    chk(r4_bad == 0, "R4", "changes with clock high", 64'(r4_bad), 0);
    if (rd) chk(rd_data === exp_rd, "R6", "read data", 64'(rd_data), 64'(exp_rd));
    else    chk(rd_data === exp_rd, "R10", "read data kept", 64'(rd_data), 64'(exp_rd));
    // clear with zero keeps the flag, clear with one drops it
    @(negedge clk); evt_wr = 1'b1; evt_wdata = 1'b0;
    @(negedge clk); evt_wr = 1'b0;
    chk(evt_flag === 1'b1, "R8", "flag after zero write", 64'(evt_flag), 1);
    evt_wr = 1'b1; evt_wdata = 1'b1;
    @(negedge clk); evt_wr = 1'b0; evt_wdata = 1'b0;
    chk(evt_flag === 1'b0, "R8", "flag after one write", 64'(evt_flag), 0);
  endtask

  // fields: rd | phy | reg | wdata | div | phy reply
  localparam int NV = 5;
  localparam logic [46:0] VEC [NV] = '{
    {1'b1, 5'd1,  5'd2,  16'h0000, 4'd0, 16'hA5C3},
    {1'b0, 5'd31, 5'd31, 16'hFFFF, 4'd1, 16'h0000},
    {1'b1, 5'd31, 5'd0,  16'h0000, 4'd2, 16'h0001},
    {1'b0, 5'd0,  5'd17, 16'h1234, 4'd0, 16'h0000},
    {1'b1, 5'd16, 5'd31, 16'h0000, 4'd3, 16'h8000}
  };

  initial begin
    #(8ns * 200000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_rd;
    logic [31:0] c;
    int len;
    exp_rd = '0;
    repeat (4) @(negedge clk);
    chk(mdc === 1'b0 && mdio_oe === 1'b0 && evt_flag === 1'b0 && rd_data === 16'h0,
        "R1", "reset outputs", {mdc, mdio_oe, evt_flag, rd_data}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(mdc === 1'b0 && mdio_oe === 1'b0 && evt_flag === 1'b0,
        "R1", "idle outputs", {mdc, mdio_oe, evt_flag}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [46:0] e;
      e = VEC[v];
      c = mk_cmd(e[46], e[45:41], e[40:36], e[35:20]);
      phy_val = e[15:0];
      if (e[46]) exp_rd = e[15:0];
      run_frame(c, int'(e[19:16]), 1'b1, 1'b0, len);
      verify(c, e[46], int'(e[19:16]), len, exp_rd);
    end

    // R9 and R11: second command and divider write in mid-frame
    c = mk_cmd(1'b0, 5'd5, 5'd9, 16'hC0DE);
    run_frame(c, 1, 1'b1, 1'b1, len);
    chk(ivl_bad == 0 && len - 1 == 256, "R11", "mid-frame divider ignored", 64'(len - 1), 256);
    chk(nrise == 64, "R9", "mid-frame command ignored edges", 64'(nrise), 64);
    verify(c, 1'b0, 1, len, exp_rd);

    // R11: next frame without a divider write picks up the stored value 3
    c = mk_cmd(1'b1, 5'd7, 5'd1, 16'h0);
    phy_val = 16'h7E81; exp_rd = 16'h7E81;
    run_frame(c, 3, 1'b0, 1'b0, len);
    chk(len - 1 == 512, "R11", "stored divider used", 64'(len - 1), 512);
    verify(c, 1'b1, 3, len, exp_rd);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule